// File: doc/BRIEF.md
# Triple Byte-Addressed Down-Counter

This block holds three 16-bit down-counters that a processor programs through a byte-wide register bus. Every counter owns a pair of byte registers, a low half and a high half. Writing the low half halts the counter and loads its bottom byte. Writing the high half loads the top byte and sets the counter running. The usual way to program a counter is therefore low byte first, then high byte. That order leaves the counter armed with the full 16-bit value.

A running counter steps down by one on each cycle in which the count-enable tick is high. When it steps past zero, the block raises a one-cycle underflow pulse on that counter's bit of the pulse vector, and an external interrupt controller consumes it. The first counter keeps a start value, written through the same byte registers as its count, and reloads it on underflow. The other two counters wrap to all ones and keep going.

Reads return the live count one byte at a time through a combinational read path.

Top module: `tri_down_timer`

## Requirements
- R1: After reset every counter holds 0 and is halted: ticks change no count and raise no underflow pulse.
- R2: A write to offset 2*i (counter i, i = 0..2) halts counter i and replaces bits 7:0 of its count; bits 15:8 are kept.
- R3: A write to offset 2*i+1 replaces bits 15:8 of counter i's count, keeps bits 7:0, and sets the counter running.
- R4: A running counter decrements by exactly one in each cycle with tick high; without a tick, or while halted, its count holds.
- R5: A running counter at 0 that receives a tick drives underflow bit i (bit 0 = counter at offsets 0/1, bit 1 = offsets 2/3, bit 2 = offsets 4/5) high for exactly one cycle, starting in the cycle after that tick.
- R6: Counter 0 keeps a 16-bit start value whose low and high bytes are written by the same offset-0 and offset-1 writes as its count. On underflow the count becomes the start value. Counting never alters the start value.
- R7: Counters 1 and 2 go from 0 to 0xFFFF on underflow and keep running.
- R8: Reading offset 2*i returns bits 7:0 and offset 2*i+1 returns bits 15:8 of counter i's live count; offsets 6 and 7 read as 0.
- R9: A register write in the same cycle as a tick takes precedence: the written counter takes the written byte with no decrement and no underflow from that tick.
- R10: A write to one counter's registers leaves the other counters' counts and run states unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Byte register offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle high |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| tick | input | 1 | Count enable |
| uf_pulse | output | 3 | Per-counter underflow pulses |

## Verification
Writes and ticks take effect at the clock edge where they are sampled. The new count is visible on the combinational read data right after that edge. The underflow pulse is registered, so it is high for the one cycle after the edge that saw the counter at zero with a tick. The bench drives inputs on falling edges and reads one time unit after a falling edge. Each count and pulse is therefore compared in the half cycle after the edge that produced it. Underflow bits are collected at each tick's closing falling edge, and the bench then confirms they drop one cycle later.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
   localparam int unsigned TDT_BYTE_W = 8;

   function automatic int unsigned tdt_lo_off(input int unsigned idx);
      return 2 * idx;
   endfunction

   function automatic int unsigned tdt_hi_off(input int unsigned idx);
      return 2 * idx + 1;
   endfunction
endpackage

// File: rtl/tdt_counter.sv
module tdt_counter #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned BYTE_W = 8,
   parameter bit          RELOAD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              tick,
   output logic [CNT_W-1:0]  count,
   output logic              uf
);
   localparam int unsigned HI_W = CNT_W - BYTE_W;

   logic             run_q;
   logic [CNT_W-1:0] wrap_val;
   logic             hit_zero;

   assign hit_zero = run_q && tick && (count == '0) && !wr_lo && !wr_hi;

   generate
      if (CNT_W != 2 * BYTE_W) begin : g_bad_width
         $error("tdt_counter: CNT_W must equal two bytes");
      end
      if (RELOAD) begin : g_reload
         logic [CNT_W-1:0] start_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               start_q <= '0;
            end else if (wr_lo) begin
               start_q[BYTE_W-1:0] <= wdata;
            end else if (wr_hi) begin
               start_q[CNT_W-1:BYTE_W] <= HI_W'(wdata);
            end
         end
         assign wrap_val = start_q;

         // R6: the reloaded count equals the stored start value
         assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
            uf |-> (count == start_q));
      end else begin : g_wrap
         assign wrap_val = '1;

         // R7: a free-running counter is all ones after underflow
         assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            uf |-> (count == {CNT_W{1'b1}}));
         // R5: the pulse never lasts two cycles after a wrap
         assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
            uf |=> !uf);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         run_q <= 1'b0;
         uf    <= 1'b0;
      end else begin
         uf <= hit_zero;
         if (wr_lo) begin
            count[BYTE_W-1:0] <= wdata;
            run_q             <= 1'b0;
         end else if (wr_hi) begin
            count[CNT_W-1:BYTE_W] <= HI_W'(wdata);
            run_q                 <= 1'b1;
         end else if (run_q && tick) begin
            count <= (count == '0) ? wrap_val : count - 1'b1;
         end
      end
   end

   // R2: a low-byte write leaves the counter halted
   assert_lo_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> !run_q);
   // R3: a high-byte write leaves the counter running
   assert_hi_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi && !wr_lo |=> run_q);
   // R4: no write and no active tick means the count holds
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lo && !wr_hi && !(run_q && tick) |=> $stable(count));
   // R4: a non-zero running count drops by one per tick
   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lo && !wr_hi && run_q && tick && (count != '0)
      |=> count == $past(count) - 1'b1);
   // R9: a write cycle never produces an underflow
   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo || wr_hi) |=> !uf);
endmodule

// File: rtl/tdt_readmux.sv
module tdt_readmux #(
   parameter int unsigned NUM    = 3,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NUM-1:0][CNT_W-1:0]  counts,
   output logic [BYTE_W-1:0]          rdata
);
   import tdt_pkg::*;

   always_comb begin
      rdata = '0;
      for (int unsigned i = 0; i < NUM; i++) begin
         if (addr == ADDR_W'(tdt_lo_off(i))) rdata = counts[i][BYTE_W-1:0];
         if (addr == ADDR_W'(tdt_hi_off(i))) rdata = counts[i][CNT_W-1:BYTE_W];
      end
   end

   // R8: offsets beyond the last counter read as zero
   always_comb begin
      if (32'(addr) >= 2 * NUM) begin
         assert_unmapped_zero_R8: assert (rdata == '0);
      end
   end
endmodule

// File: rtl/tri_down_timer.sv
module tri_down_timer #(
   parameter int unsigned NUM_TIMERS  = 3,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned RELOAD_MASK = 1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [$clog2(2*NUM_TIMERS)-1:0]      reg_addr,
   input  logic [tdt_pkg::TDT_BYTE_W-1:0]       reg_wdata,
   input  logic                                 reg_we,
   output logic [tdt_pkg::TDT_BYTE_W-1:0]       reg_rdata,
   input  logic                                 tick,
   output logic [NUM_TIMERS-1:0]                uf_pulse
);
   import tdt_pkg::*;

   localparam int unsigned ADDR_W = $clog2(2 * NUM_TIMERS);

   logic [NUM_TIMERS-1:0][CNT_W-1:0] counts;
   logic [NUM_TIMERS-1:0]            wr_lo;
   logic [NUM_TIMERS-1:0]            wr_hi;

   generate
      if (NUM_TIMERS < 1 || NUM_TIMERS > 16) begin : g_bad_num
         $error("tri_down_timer: NUM_TIMERS out of range");
      end
      if (CNT_W != 2 * TDT_BYTE_W) begin : g_bad_cnt
         $error("tri_down_timer: CNT_W must be two bytes");
      end
      for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_ctr
         assign wr_lo[i] = reg_we && (reg_addr == ADDR_W'(tdt_lo_off(i)));
         assign wr_hi[i] = reg_we && (reg_addr == ADDR_W'(tdt_hi_off(i)));

         tdt_counter #(
            .CNT_W  (CNT_W),
            .BYTE_W (TDT_BYTE_W),
            .RELOAD (RELOAD_MASK[i])
         ) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (wr_lo[i]),
            .wr_hi (wr_hi[i]),
            .wdata (reg_wdata),
            .tick  (tick),
            .count (counts[i]),
            .uf    (uf_pulse[i])
         );

         // R10: a write aimed elsewhere leaves this count alone unless it ticks
         assert_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
            reg_we && !wr_lo[i] && !wr_hi[i] && !tick |=> $stable(counts[i]));
      end
   endgenerate

   tdt_readmux #(
      .NUM    (NUM_TIMERS),
      .CNT_W  (CNT_W),
      .BYTE_W (TDT_BYTE_W),
      .ADDR_W (ADDR_W)
   ) u_rd (
      .addr   (reg_addr),
      .counts (counts),
      .rdata  (reg_rdata)
   );

   // R1: no underflow pulse in the first cycle out of reset
   assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (uf_pulse == '0));
endmodule

// File: tb/tri_down_timer_test.sv
module tri_down_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_rdata;
   logic       tick = 1'b0;
   logic [2:0] uf_pulse;

   int checks = 0;
   int fails  = 0;
   int uf_seen [3];
   bit done = 1'b0;

   always #2 clk = ~clk;

   tri_down_timer uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .tick(tick), .uf_pulse(uf_pulse)
   );

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d, input bit with_tick = 1'b0);
      @(negedge clk);
      reg_addr = 3'(a); reg_wdata = 8'(d); reg_we = 1'b1; tick = with_tick;
      @(negedge clk);
      reg_we = 1'b0; tick = 1'b0;
      #1;
      for (int b = 0; b < 3; b++) if (uf_pulse[b]) uf_seen[b]++;
   endtask

   task automatic rd16(input int t, output int v);
      logic [7:0] lo;
      @(negedge clk);
      reg_addr = 3'(2 * t); #1 lo = reg_rdata;
      reg_addr = 3'(2 * t + 1); #1 v = {reg_rdata, lo};
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         #1;
         for (int b = 0; b < 3; b++) if (uf_pulse[b]) uf_seen[b]++;
      end
   endtask

   task automatic clear_seen();
      for (int b = 0; b < 3; b++) uf_seen[b] = 0;
   endtask

   task automatic halt_all();
      wr(0, 0); wr(2, 0); wr(4, 0);
   endtask

   task automatic t_reset();
      int v;
      clear_seen();
      for (int t = 0; t < 3; t++) begin rd16(t, v); chk("R1 reset count", v, 0); end
      ticks(5);
      for (int t = 0; t < 3; t++) begin rd16(t, v); chk("R1 halted after ticks", v, 0); end
      chk("R1 no pulse", uf_seen[0] + uf_seen[1] + uf_seen[2], 0);
   endtask

   task automatic t_load_count_halt();
      int v;
      wr(0, 8'h05); wr(1, 8'h00);
      rd16(0, v); chk("R3 loaded count", v, 16'h0005);
      ticks(3);
      rd16(0, v); chk("R4 three ticks", v, 16'h0002);
      repeat (4) @(negedge clk);
      rd16(0, v); chk("R4 no tick holds", v, 16'h0002);
      wr(0, 8'h07);
      rd16(0, v); chk("R2 low write", v, 16'h0007);
      ticks(4);
      rd16(0, v); chk("R2 halted", v, 16'h0007);
   endtask

   task automatic t_reload();
      int v;
      clear_seen();
      wr(0, 8'h03); wr(1, 8'h00);
      ticks(3);
      rd16(0, v); chk("R4 down to zero", v, 0);
      chk("R5 no early pulse", uf_seen[0], 0);
      ticks(1);
      chk("R5 pulse bit0", uf_seen[0], 1);
      rd16(0, v); chk("R6 reload", v, 16'h0003);
      chk("R5 pulse one cycle", int'(uf_pulse[0]), 0);
      ticks(4);
      rd16(0, v); chk("R6 second reload", v, 16'h0003);
      chk("R5 second pulse", uf_seen[0], 2);
      wr(1, 8'h01);
      rd16(0, v); chk("R3 high keeps low", v, 16'h0103);
      ticks(2);
      rd16(0, v); chk("R3 running after high", v, 16'h0101);
      chk("R5 other bits quiet", uf_seen[1] + uf_seen[2], 0);
   endtask

   task automatic t_wrap();
      int v;
      halt_all();
      clear_seen();
      wr(2, 8'h01); wr(3, 8'h00);
      ticks(2);
      rd16(1, v); chk("R7 counter1 wraps", v, 16'hFFFF);
      chk("R5 pulse bit1", uf_seen[1], 1);
      ticks(1);
      rd16(1, v); chk("R7 keeps running", v, 16'hFFFE);
      rd16(0, v); chk("R10 counter0 untouched", v, 16'h0100);
      wr(2, 8'h00);
      wr(4, 8'h00); wr(5, 8'h00);
      ticks(1);
      rd16(2, v); chk("R7 counter2 wraps", v, 16'hFFFF);
      chk("R5 pulse bit2", uf_seen[2], 1);
      rd16(1, v); chk("R10 counter1 halted", v, 16'hFF00);
      chk("R5 bit0 quiet", uf_seen[0], 0);
   endtask

   task automatic t_unmapped();
      @(negedge clk);
      reg_addr = 3'd6; #1 chk("R8 offset 6", int'(reg_rdata), 0);
      reg_addr = 3'd7; #1 chk("R8 offset 7", int'(reg_rdata), 0);
      reg_addr = 3'd5; #1 chk("R8 high byte", int'(reg_rdata), 8'hFF);
   endtask

   task automatic t_write_vs_tick();
      int v;
      halt_all();
      wr(4, 8'h10); wr(5, 8'h00);
      wr(4, 8'h20, 1'b1);
      rd16(2, v); chk("R9 low write beats tick", v, 16'h0020);
      wr(5, 8'h00, 1'b1);
      rd16(2, v); chk("R9 high write beats tick", v, 16'h0020);
      ticks(1);
      rd16(2, v); chk("R9 runs after write", v, 16'h001F);
      clear_seen();
      wr(2, 8'h00); wr(3, 8'h00);
      wr(3, 8'h00, 1'b1);
      rd16(1, v); chk("R9 zero held on write", v, 0);
      chk("R9 no pulse on write", uf_seen[1], 0);
   endtask

   initial begin
      clear_seen();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load_count_halt();
      t_reload();
      t_wrap();
      t_unmapped();
      t_write_vs_tick();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule